// File: doc/BRIEF.md
# Instruction Prefix and Opcode Classifier

This block is the first stage of an instruction front end for a variable-length byte-coded instruction set running in its 64-bit mode. Instruction bytes arrive one per cycle over a valid/ready stream. The block collects any legacy prefixes and an optional register-extension prefix. It then recognises either a one-byte opcode or a two-byte opcode that starts with the escape byte 0F. When the opcode carries an operand-form byte (mod/reg/rm), the block takes that byte as well.

For each instruction the block presents one record: the five prefix flags, the four extension bits, the opcode and its escape flag, the mod/reg/rm fields widened by the extension bits, a class code for a small supported subset, and an illegal flag. A lead byte of a vector-escape encoding is detected and reported; its payload is not decoded. Length decoding, displacement bytes and immediate bytes are handled by later stages.

The record is held until the downstream stage takes it. No input byte is accepted while a record is waiting.

Top module: `pfx_op_classifier`

## Requirements
- R1: The legacy prefix bytes F0, F2, F3, 66 and 67 set lock_o, repne_o, rep_o, osz_o and asz_o respectively. They may come in any order, and a repeated prefix is accepted without error.
- R2: Bytes 40 to 4F are register-extension prefixes. Bits [3:0] of the byte appear on ext_o as W, R, X, B, from bit 3 down to bit 0. The form byte is split as mod=[7:6], reg=[5:3], rm=[2:0]. reg_o is {R, reg} and rm_o is {B, rm}.
- R3: An extension prefix that is followed by a legacy prefix is discarded, so ext_o reads 0 unless another extension byte arrives later.
- R4: A vector lead byte (C4, C5 or 62 with no escape before it) ends the instruction at once. It gives class 9 with vec_lead_o=1 and takes no further bytes. If the instruction already contains an extension prefix or a vector lead byte, a second one sets illegal_o.
- R5: Opcode 90 gives class 1 (no-operation) when B=0. When B=1 it gives class 2 (exchange with register 8), with rm_o=8.
- R6: Escaped opcode 01 with mod≠3 gives class 6, and reg_o selects the system-table operation. reg values 4 and 5 set illegal_o. With mod=3 it gives class 7, which carries reg_o and rm_o.
- R7: Escaped opcode D6 (class 8) requires a 66 prefix as the last legacy prefix before the escape byte. An extension prefix may sit between the 66 and the escape byte. Without this, illegal_o is set.
- R8: A lock prefix is legal only on opcode 01 (one-byte, class 3) with mod≠3. On any other opcode, or with mod=3, it sets illegal_o.
- R9: Up to 14 prefix bytes are accepted. The 15th prefix byte aborts the instruction with class 10 and illegal_o=1. The next byte after the record is taken starts a fresh instruction.
- R10: The record holds stable while rec_valid_o=1 and rec_ready_i=0, and ready_o stays low for that time.
- R11: One-byte opcode 89 with a form byte gives class 4, and C3 gives class 5. Every other opcode gives class 0 with no form byte. opcode_o holds the final opcode byte, and esc_o=1 marks the escaped opcodes.
- R12: After reset, rec_valid_o=0 and ready_o=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| byte_i | input | 8 | Instruction byte |
| valid_i | input | 1 | byte_i is valid |
| ready_o | output | 1 | Stage can accept a byte |
| rec_valid_o | output | 1 | Decoded record is available |
| rec_ready_i | input | 1 | Downstream takes the record |
| lock_o | output | 1 | F0 seen |
| repne_o | output | 1 | F2 seen |
| rep_o | output | 1 | F3 seen |
| osz_o | output | 1 | 66 seen |
| asz_o | output | 1 | 67 seen |
| ext_o | output | 4 | Effective extension bits W,R,X,B |
| esc_o | output | 1 | Opcode was escaped by 0F |
| opcode_o | output | 8 | Final opcode byte |
| mod_o | output | 2 | Form byte mod field |
| reg_o | output | 4 | Extended reg field |
| rm_o | output | 4 | Extended rm field |
| class_o | output | 4 | Class code |
| illegal_o | output | 1 | Instruction is illegal |
| vec_lead_o | output | 1 | Vector lead byte detected |

## Verification
The hardest cases to reach from the ports are the ones where ordering matters more than content. Examples are a 66 prefix that is valid only while it stays adjacent to the escape byte, and an extension byte that a later prefix makes void. The directed sequences place an extension byte between 66 and the escape, put another legacy prefix after 66, and insert 66 after an extension byte. The expected effect is read from ext_o, reg_o, rm_o and illegal_o. The prefix limit is reached by sending exactly fourteen prefixes and then one more. A plain opcode is then sent to show that the aborted instruction left no flag behind.

// File: rtl/pfx_op_pkg.sv
package pfx_op_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [3:0] {
    CLS_OTHER    = 4'd0,
    CLS_NOP      = 4'd1,
    CLS_XCHG_EXT = 4'd2,
    CLS_ADD_RM   = 4'd3,
    CLS_MOV_RM   = 4'd4,
    CLS_RET      = 4'd5,
    CLS_SYS_TAB  = 4'd6,
    CLS_REG_GRP  = 4'd7,
    CLS_VMOV_Q   = 4'd8,
    CLS_VEC_LEAD = 4'd9,
    CLS_ABORT    = 4'd10
  } cls_e;

  typedef struct packed {
    logic lock;
    logic repne;
    logic rep;
    logic osz;
    logic asz;
  } pfx_t;

  typedef struct packed {
    logic w;
    logic r;
    logic x;
    logic b;
  } ext_t;

  typedef struct packed {
    logic is_esc;
    logic needs_form;
    logic lockable;
    logic need_osz;
    logic vec_lead;
    cls_e cls;
  } opinfo_t;

  localparam logic [BYTE_W-1:0] B_ESC   = 8'h0F;
  localparam logic [BYTE_W-1:0] B_LOCK  = 8'hF0;
  localparam logic [BYTE_W-1:0] B_REPNE = 8'hF2;
  localparam logic [BYTE_W-1:0] B_REP   = 8'hF3;
  localparam logic [BYTE_W-1:0] B_OSZ   = 8'h66;
  localparam logic [BYTE_W-1:0] B_ASZ   = 8'h67;
endpackage

// File: rtl/pfx_track.sv
module pfx_track
  import pfx_op_pkg::*;
#(
  parameter int MAX_PFX = 14,
  localparam int CNT_W = $clog2(MAX_PFX + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              take_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic              is_legacy_o,
  output logic              is_ext_o,
  output logic              full_o,
  output pfx_t              pfx_o,
  output ext_t              ext_o,
  output logic              ext_any_o,
  output logic              ext_dup_o,
  output logic              osz_last_o
);
  logic [CNT_W-1:0] cnt_q;
  pfx_t             pfx_q;
  ext_t             ext_q;
  logic             any_q, dup_q, osz_last_q;

  assign is_legacy_o = (byte_i == B_LOCK) || (byte_i == B_REPNE) || (byte_i == B_REP) ||
                       (byte_i == B_OSZ)  || (byte_i == B_ASZ);
  assign is_ext_o    = (byte_i[7:4] == 4'h4);
  assign full_o      = (cnt_q == CNT_W'(MAX_PFX));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q      <= '0;
      pfx_q      <= '0;
      ext_q      <= '0;
      any_q      <= 1'b0;
      dup_q      <= 1'b0;
      osz_last_q <= 1'b0;
    end else if (clr_i) begin
      cnt_q      <= '0;
      pfx_q      <= '0;
      ext_q      <= '0;
      any_q      <= 1'b0;
      dup_q      <= 1'b0;
      osz_last_q <= 1'b0;
    end else if (take_i) begin
      cnt_q <= cnt_q + 1'b1;
      if (is_legacy_o) begin
        // an extension byte counts only as the last prefix
        ext_q      <= '0;
        osz_last_q <= (byte_i == B_OSZ);
        unique case (byte_i)
          B_LOCK:  pfx_q.lock  <= 1'b1;
          B_REPNE: pfx_q.repne <= 1'b1;
          B_REP:   pfx_q.rep   <= 1'b1;
          B_OSZ:   pfx_q.osz   <= 1'b1;
          default: pfx_q.asz   <= 1'b1;
        endcase
      end else if (is_ext_o) begin
        dup_q <= dup_q | any_q;
        any_q <= 1'b1;
        ext_q <= ext_t'(byte_i[3:0]);
      end
    end
  end

  assign pfx_o      = pfx_q;
  assign ext_o      = ext_q;
  assign ext_any_o  = any_q;
  assign ext_dup_o  = dup_q;
  assign osz_last_o = osz_last_q;
endmodule

// File: rtl/op_table.sv
module op_table
  import pfx_op_pkg::*;
(
  input  logic              esc_i,
  input  logic [BYTE_W-1:0] op_i,
  output opinfo_t           info_o
);
  always_comb begin
    info_o     = '0;
    info_o.cls = CLS_OTHER;
    if (!esc_i) begin
      unique case (op_i)
        B_ESC: info_o.is_esc = 1'b1;
        8'h01: begin
          info_o.needs_form = 1'b1;
          info_o.lockable   = 1'b1;
          info_o.cls        = CLS_ADD_RM;
        end
        8'h89: begin
          info_o.needs_form = 1'b1;
          info_o.cls        = CLS_MOV_RM;
        end
        8'h90: info_o.cls = CLS_NOP;
        8'hC3: info_o.cls = CLS_RET;
        8'hC4, 8'hC5, 8'h62: begin
          info_o.vec_lead = 1'b1;
          info_o.cls      = CLS_VEC_LEAD;
        end
        default: ;
      endcase
    end else begin
      unique case (op_i)
        8'h01: begin
          info_o.needs_form = 1'b1;
          info_o.cls        = CLS_SYS_TAB;
        end
        8'hD6: begin
          info_o.needs_form = 1'b1;
          info_o.need_osz   = 1'b1;
          info_o.cls        = CLS_VMOV_Q;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/form_resolve.sv
module form_resolve
  import pfx_op_pkg::*;
(
  input  opinfo_t           info_i,
  input  logic              form_vld_i,
  input  logic [BYTE_W-1:0] form_i,
  input  logic              lock_i,
  input  logic              osz_ok_i,
  input  ext_t              ext_i,
  input  logic              dup_i,
  output cls_e              cls_o,
  output logic              ill_o,
  output logic [1:0]        mod_o,
  output logic [3:0]        reg_o,
  output logic [3:0]        rm_o
);
  logic mem_form, lock_ok, sys_bad;

  always_comb begin
    mod_o = form_vld_i ? form_i[7:6] : 2'b00;
    reg_o = form_vld_i ? {ext_i.r, form_i[5:3]} : 4'd0;
    if (form_vld_i)                 rm_o = {ext_i.b, form_i[2:0]};
    else if (info_i.cls == CLS_NOP) rm_o = {ext_i.b, 3'b000};
    else                            rm_o = 4'd0;

    mem_form = form_vld_i && (form_i[7:6] != 2'b11);

    cls_o = info_i.cls;
    if (info_i.cls == CLS_NOP && ext_i.b)        cls_o = CLS_XCHG_EXT;
    if (info_i.cls == CLS_SYS_TAB && !mem_form)  cls_o = CLS_REG_GRP;

    lock_ok = info_i.lockable && mem_form;
    sys_bad = (info_i.cls == CLS_SYS_TAB) && mem_form && (form_i[5:4] == 2'b10);
    ill_o   = dup_i || (lock_i && !lock_ok) || (info_i.need_osz && !osz_ok_i) || sys_bad;
  end
endmodule

// File: rtl/pfx_op_classifier.sv
module pfx_op_classifier
  import pfx_op_pkg::*;
#(
  parameter int MAX_PFX = 14
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [7:0] byte_i,
  input  logic       valid_i,
  output logic       ready_o,
  output logic       rec_valid_o,
  input  logic       rec_ready_i,
  output logic       lock_o,
  output logic       repne_o,
  output logic       rep_o,
  output logic       osz_o,
  output logic       asz_o,
  output logic [3:0] ext_o,
  output logic       esc_o,
  output logic [7:0] opcode_o,
  output logic [1:0] mod_o,
  output logic [3:0] reg_o,
  output logic [3:0] rm_o,
  output logic [3:0] class_o,
  output logic       illegal_o,
  output logic       vec_lead_o
);
  typedef enum logic [1:0] {ST_PFX, ST_ESC, ST_FORM, ST_OUT} st_e;

  st_e              st_q;
  logic             esc_q, osz_ok_q;
  logic [BYTE_W-1:0] op_q;

  logic    acc, in_pfx, pfx_byte, take, abort, clr, finish, go_esc, go_form;
  logic    is_legacy, is_ext, full, ext_any, ext_dup, osz_last, osz_ok, dup;
  logic    tbl_esc;
  logic [BYTE_W-1:0] tbl_op;
  pfx_t    pfx;
  ext_t    ext;
  opinfo_t info;
  cls_e    res_cls;
  logic    res_ill;
  logic [1:0] res_mod;
  logic [3:0] res_reg, res_rm;

  pfx_t    r_pfx;
  ext_t    r_ext;
  logic    r_esc, r_ill, r_vec;
  logic [BYTE_W-1:0] r_op;
  logic [1:0] r_mod;
  logic [3:0] r_reg, r_rm;
  cls_e    r_cls;

  assign ready_o  = (st_q != ST_OUT);
  assign acc      = valid_i && ready_o;
  assign in_pfx   = (st_q == ST_PFX);
  assign pfx_byte = is_legacy || is_ext;
  assign take     = acc && in_pfx && pfx_byte && !full;
  assign abort    = acc && in_pfx && pfx_byte && full;
  assign clr      = (st_q == ST_OUT) && rec_ready_i;

  pfx_track #(.MAX_PFX(MAX_PFX)) u_track (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (clr),
    .take_i      (take),
    .byte_i      (byte_i),
    .is_legacy_o (is_legacy),
    .is_ext_o    (is_ext),
    .full_o      (full),
    .pfx_o       (pfx),
    .ext_o       (ext),
    .ext_any_o   (ext_any),
    .ext_dup_o   (ext_dup),
    .osz_last_o  (osz_last)
  );

  assign tbl_esc = (st_q == ST_ESC) || ((st_q == ST_FORM) && esc_q);
  assign tbl_op  = (st_q == ST_FORM) ? op_q : byte_i;

  op_table u_tbl (
    .esc_i  (tbl_esc),
    .op_i   (tbl_op),
    .info_o (info)
  );

  // the 66 adjacency is judged at the first opcode byte
  assign osz_ok = in_pfx ? osz_last : osz_ok_q;
  assign dup    = info.vec_lead ? ext_any : ext_dup;

  form_resolve u_res (
    .info_i     (info),
    .form_vld_i (st_q == ST_FORM),
    .form_i     (byte_i),
    .lock_i     (pfx.lock),
    .osz_ok_i   (osz_ok),
    .ext_i      (ext),
    .dup_i      (dup),
    .cls_o      (res_cls),
    .ill_o      (res_ill),
    .mod_o      (res_mod),
    .reg_o      (res_reg),
    .rm_o       (res_rm)
  );

  assign go_esc  = acc && in_pfx && !pfx_byte && info.is_esc;
  assign go_form = acc && ((in_pfx && !pfx_byte && !info.is_esc && info.needs_form) ||
                           ((st_q == ST_ESC) && info.needs_form));
  assign finish  = acc && ((in_pfx && !pfx_byte && !info.is_esc && !info.needs_form) ||
                           ((st_q == ST_ESC) && !info.needs_form) ||
                           (st_q == ST_FORM));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_PFX;
      esc_q    <= 1'b0;
      osz_ok_q <= 1'b0;
      op_q     <= '0;
    end else begin
      if (abort || finish) st_q <= ST_OUT;
      else if (go_esc)     st_q <= ST_ESC;
      else if (go_form)    st_q <= ST_FORM;
      else if (clr)        st_q <= ST_PFX;

      if (go_esc) begin
        esc_q    <= 1'b1;
        osz_ok_q <= osz_last;
      end else if (clr) begin
        esc_q <= 1'b0;
      end
      if (go_form) begin
        op_q <= byte_i;
        if (in_pfx) osz_ok_q <= osz_last;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      r_pfx <= '0;
      r_ext <= '0;
      r_esc <= 1'b0;
      r_ill <= 1'b0;
      r_vec <= 1'b0;
      r_op  <= '0;
      r_mod <= '0;
      r_reg <= '0;
      r_rm  <= '0;
      r_cls <= CLS_OTHER;
    end else if (abort) begin
      r_pfx <= pfx;
      r_ext <= ext;
      r_esc <= 1'b0;
      r_ill <= 1'b1;
      r_vec <= 1'b0;
      r_op  <= byte_i;
      r_mod <= '0;
      r_reg <= '0;
      r_rm  <= '0;
      r_cls <= CLS_ABORT;
    end else if (finish) begin
      r_pfx <= pfx;
      r_ext <= ext;
      r_esc <= tbl_esc;
      r_ill <= res_ill;
      r_vec <= info.vec_lead;
      r_op  <= tbl_op;
      r_mod <= res_mod;
      r_reg <= res_reg;
      r_rm  <= res_rm;
      r_cls <= res_cls;
    end
  end

  assign rec_valid_o = (st_q == ST_OUT);
  assign lock_o      = r_pfx.lock;
  assign repne_o     = r_pfx.repne;
  assign rep_o       = r_pfx.rep;
  assign osz_o       = r_pfx.osz;
  assign asz_o       = r_pfx.asz;
  assign ext_o       = r_ext;
  assign esc_o       = r_esc;
  assign opcode_o    = r_op;
  assign mod_o       = r_mod;
  assign reg_o       = r_reg;
  assign rm_o        = r_rm;
  assign class_o     = r_cls;
  assign illegal_o   = r_ill;
  assign vec_lead_o  = r_vec;
endmodule

// File: rtl/pfx_op_classifier_chk.sv
module pfx_op_classifier_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       ready_o,
  input logic       rec_valid_o,
  input logic       rec_ready_i,
  input logic       lock_o,
  input logic [3:0] ext_o,
  input logic       esc_o,
  input logic [7:0] opcode_o,
  input logic [1:0] mod_o,
  input logic [3:0] reg_o,
  input logic [3:0] rm_o,
  input logic [3:0] class_o,
  input logic       illegal_o,
  input logic       vec_lead_o
);
  // R10
  rec_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_o && !rec_ready_i |=> rec_valid_o && !ready_o && $stable(opcode_o) &&
    $stable(class_o) && $stable(illegal_o) && $stable(reg_o) && $stable(rm_o));

  // R9
  abort_ill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_o && class_o == 4'd10 |-> illegal_o);

  // R5
  nop_no_b_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_o && class_o == 4'd1 |-> !ext_o[0] && opcode_o == 8'h90 && !esc_o);

  // R6
  reg_grp_form_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_o && class_o == 4'd7 |-> mod_o == 2'b11 && esc_o);

  // R6
  sys_tab_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_o && class_o == 4'd6 && !illegal_o |-> mod_o != 2'b11 && reg_o[2:1] != 2'b10);

  // R8
  lock_reg_form_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_o && class_o == 4'd3 && lock_o && mod_o == 2'b11 |-> illegal_o);

  // R4
  vec_lead_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_o && class_o == 4'd9 |-> vec_lead_o && !esc_o);
endmodule

bind pfx_op_classifier pfx_op_classifier_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ready_o     (ready_o),
  .rec_valid_o (rec_valid_o),
  .rec_ready_i (rec_ready_i),
  .lock_o      (lock_o),
  .ext_o       (ext_o),
  .esc_o       (esc_o),
  .opcode_o    (opcode_o),
  .mod_o       (mod_o),
  .reg_o       (reg_o),
  .rm_o        (rm_o),
  .class_o     (class_o),
  .illegal_o   (illegal_o),
  .vec_lead_o  (vec_lead_o)
);

// File: tb/pfx_op_classifier_bench.sv
`timescale 1ns/1ps
module pfx_op_classifier_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] byte_i = 8'h00;
  logic       valid_i = 1'b0;
  logic       rec_ready_i = 1'b0;
  logic       ready_o, rec_valid_o, lock_o, repne_o, rep_o, osz_o, asz_o;
  logic [3:0] ext_o, reg_o, rm_o, class_o;
  logic       esc_o, illegal_o, vec_lead_o;
  logic [7:0] opcode_o;
  logic [1:0] mod_o;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk_i = ~clk_i;

  pfx_op_classifier u_pfx_op_classifier (
    .clk_i(clk_i), .rst_ni(rst_ni), .byte_i(byte_i), .valid_i(valid_i), .ready_o(ready_o),
    .rec_valid_o(rec_valid_o), .rec_ready_i(rec_ready_i), .lock_o(lock_o), .repne_o(repne_o),
    .rep_o(rep_o), .osz_o(osz_o), .asz_o(asz_o), .ext_o(ext_o), .esc_o(esc_o),
    .opcode_o(opcode_o), .mod_o(mod_o), .reg_o(reg_o), .rm_o(rm_o), .class_o(class_o),
    .illegal_o(illegal_o), .vec_lead_o(vec_lead_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    byte_i  = b;
    valid_i = 1'b1;
    @(negedge clk_i);
    valid_i = 1'b0;
  endtask

  task automatic take_rec();
    rec_ready_i = 1'b1;
    @(negedge clk_i);
    rec_ready_i = 1'b0;
  endtask

  task automatic rec(input string tag, input int cls, input int ill);
    chk({tag, " valid"}, rec_valid_o, 1);
    chk({tag, " class"}, class_o, cls);
    chk({tag, " illegal"}, illegal_o, ill);
  endtask

  task automatic t_reset();
    chk("R12 rec_valid", rec_valid_o, 0);
    chk("R12 ready", ready_o, 1);
  endtask

  task automatic t_prefixes();
    send(8'hF3); send(8'h67); send(8'hF2); send(8'h66); send(8'hF0); send(8'hF3);
    send(8'h01); send(8'h08);
    rec("R1 mixed", 3, 0);
    chk("R1 flags", {lock_o, repne_o, rep_o, osz_o, asz_o}, 5'b11111);
    chk("R2 reg", reg_o, 1);
    chk("R11 opcode", opcode_o, 8'h01);
    take_rec();
    send(8'h67); send(8'hC3);
    chk("R1 asz only", {lock_o, repne_o, rep_o, osz_o, asz_o}, 5'b00001);
    rec("R11 ret", 5, 0);
    take_rec();
  endtask

  task automatic t_ext();
    send(8'h4D); send(8'h89); send(8'hC3);
    rec("R2 mov", 4, 0);
    chk("R2 ext", ext_o, 4'hD);
    chk("R2 mod", mod_o, 3);
    chk("R2 reg", reg_o, 8);
    chk("R2 rm", rm_o, 11);
    take_rec();
    send(8'h44); send(8'h66); send(8'h89); send(8'hD8);
    rec("R3 discard", 4, 0);
    chk("R3 ext", ext_o, 0);
    chk("R3 reg", reg_o, 3);
    chk("R3 rm", rm_o, 0);
    take_rec();
  endtask

  task automatic t_dup_vec();
    send(8'h48); send(8'h41); send(8'hC3);
    rec("R4 two ext", 5, 1);
    take_rec();
    send(8'hC5);
    rec("R4 vec lead", 9, 0);
    chk("R4 vec flag", vec_lead_o, 1);
    take_rec();
    send(8'hC3);
    rec("R4 next byte new instr", 5, 0);
    take_rec();
    send(8'h40); send(8'hC4);
    rec("R4 ext then vec", 9, 1);
    take_rec();
  endtask

  task automatic t_nop();
    send(8'h90);
    rec("R5 nop", 1, 0);
    take_rec();
    send(8'h41); send(8'h90);
    rec("R5 xchg", 2, 0);
    chk("R5 rm", rm_o, 8);
    take_rec();
    send(8'h48); send(8'h90);
    rec("R5 w only", 1, 0);
    take_rec();
  endtask

  task automatic t_sys();
    send(8'h0F); send(8'h01); send(8'h10);
    rec("R6 mem", 6, 0);
    chk("R6 reg", reg_o, 2);
    chk("R11 esc", esc_o, 1);
    take_rec();
    send(8'h0F); send(8'h01); send(8'h28);
    rec("R6 bad reg", 6, 1);
    take_rec();
    send(8'h0F); send(8'h01); send(8'hD9);
    rec("R6 regform", 7, 0);
    chk("R6 pair", {reg_o, rm_o}, 8'h31);
    take_rec();
    send(8'h4C); send(8'h0F); send(8'h01); send(8'hF8);
    rec("R6 ext regform", 7, 0);
    chk("R6 ext pair", {reg_o, rm_o}, 8'hF0);
    take_rec();
  endtask

  task automatic t_mand();
    send(8'h66); send(8'h0F); send(8'hD6); send(8'hC0);
    rec("R7 ok", 8, 0);
    take_rec();
    send(8'h0F); send(8'hD6); send(8'hC0);
    rec("R7 missing", 8, 1);
    take_rec();
    send(8'h66); send(8'hF3); send(8'h0F); send(8'hD6); send(8'hC0);
    rec("R7 not last", 8, 1);
    take_rec();
    send(8'h66); send(8'h41); send(8'h0F); send(8'hD6); send(8'hC0);
    rec("R7 ext between", 8, 0);
    chk("R7 rm", rm_o, 8);
    take_rec();
  endtask

  task automatic t_lock();
    send(8'hF0); send(8'h89); send(8'h00);
    rec("R8 mov", 4, 1);
    take_rec();
    send(8'hF0); send(8'h01); send(8'hC0);
    rec("R8 add regform", 3, 1);
    take_rec();
    send(8'hF0); send(8'hC3);
    rec("R8 ret", 5, 1);
    take_rec();
    send(8'hF0); send(8'h0F); send(8'h01); send(8'h10);
    rec("R8 sys", 6, 1);
    take_rec();
  endtask

  task automatic t_abort();
    for (int i = 0; i < 14; i++) send(8'h66);
    send(8'h90);
    rec("R9 fourteen ok", 1, 0);
    chk("R9 osz", osz_o, 1);
    take_rec();
    for (int i = 0; i < 14; i++) send(8'h66);
    chk("R9 still collecting", rec_valid_o, 0);
    send(8'h67);
    rec("R9 abort", 10, 1);
    take_rec();
    send(8'hC3);
    rec("R9 resync", 5, 0);
    chk("R9 flags cleared", osz_o, 0);
    take_rec();
  endtask

  task automatic t_hold();
    send(8'hC3);
    byte_i  = 8'hF0;
    valid_i = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk_i);
      chk("R10 ready low", ready_o, 0);
      rec("R10 held", 5, 0);
    end
    valid_i = 1'b0;
    take_rec();
    chk("R10 released", rec_valid_o, 0);
    send(8'hC3);
    chk("R10 byte not taken", lock_o, 0);
    rec("R10 next", 5, 0);
    take_rec();
  endtask

  task automatic t_other();
    send(8'h0F); send(8'h0B);
    rec("R11 esc other", 0, 0);
    chk("R11 esc op", {esc_o, opcode_o}, 9'h10B);
    take_rec();
    send(8'h37);
    rec("R11 other", 0, 0);
    chk("R11 plain op", {esc_o, opcode_o}, 9'h037);
    take_rec();
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_prefixes();
    t_ext();
    t_dup_vec();
    t_nop();
    t_sys();
    t_mand();
    t_lock();
    t_abort();
    t_hold();
    t_other();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #500000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got 0 expected 1");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule